// File: doc/BRIEF.md
# Delayed Sweep Start Logic

This block decides when a second, delayed timebase sweep begins relative to the main sweep, and when it stops. The delay is counted from the start of the main sweep by logic outside this block, which reports expiry as a one-cycle event. A delayed sweep can therefore only exist while the main sweep runs. The block drives a gate that enables the delayed ramp, and a display-select output that marks the intensified stretch of the main sweep during which the delayed sweep is active.

There are two ways to start. The choice comes from the trigger level setting. With the level code at its top end, all ones, the block is in run-on-expiry mode: the gate opens as soon as the delay has elapsed, and trigger pulses have no effect. At any other level the block is in triggered mode: after the delay expires it arms, and the first trigger pulse that comes afterwards opens the gate. The gate closes on the delayed sweep's own end signal or when the main sweep ends, whichever happens first. At most one delayed sweep starts during each main sweep.

Top module: `dly_sweep_start`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it, dlyGate and dispSel are 0.
- R2: In run-on-expiry mode (trigLevel all ones), if delayDone is sampled high at a clock edge while mainActive is high, dlyGate is 1 after that edge.
- R3: In triggered mode (trigLevel not all ones), dlyGate rises after the edge that samples the first dlyTrig pulse following the delayDone event. A dlyTrig sampled in the same cycle as delayDone does not count as following it.
- R4: In triggered mode, dlyTrig pulses sampled before delayDone in the current main sweep do not open dlyGate.
- R5: In run-on-expiry mode, dlyTrig has no effect: it opens no gate before expiry, and it opens none after a delayed sweep has ended.
- R6: A delayDone sampled while mainActive is low is ignored. dlyGate only rises from an edge where mainActive was high.
- R7: If dlySweepEnd is sampled high while the gate is open, dlyGate is 0 after that edge.
- R8: If mainActive is sampled low, dlyGate is 0 after that edge, and any armed or spent state is cleared.
- R9: At most one delayed sweep starts per main sweep. Once the gate has closed, further delayDone or dlyTrig inputs are ignored until mainActive has gone low and high again.
- R10: dispSel equals dlyGate at every cycle. It is high exactly while the delayed sweep is active.
- R11: If trigLevel moves to all ones while the block is armed in triggered mode, dlyGate opens after the next edge without a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mainActive | input | 1 | High while the main sweep runs |
| delayDone | input | 1 | One-cycle pulse: the delay time has elapsed |
| dlyTrig | input | 1 | One-cycle delayed-trigger pulse |
| trigLevel | input | LVL_W | Trigger level code; all ones selects run-on-expiry mode |
| dlySweepEnd | input | 1 | Delayed ramp has reached its end |
| dlyGate | output | 1 | Delayed-sweep gate |
| dispSel | output | 1 | Display select: high while the delayed sweep is shown |

## Verification
The checker watches several properties on every cycle:
- the gate closes after the main sweep ends or after the delayed sweep's own end;
- the gate only opens from inside a main sweep;
- the gate opens at most once per main sweep;
- a triggered-mode start is always preceded by a trigger;
- display select always tracks the gate.

Other behaviour depends on a particular ordering of inputs, so only the bench's scenarios can show it:
- the gate opens in exactly the cycle after expiry or after the trigger;
- a trigger that coincides with expiry is rejected;
- triggers arriving before expiry are discarded;
- a move of the level setting to its top end while armed starts the sweep at once.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Sequencing of one main sweep as seen by the delayed-start logic.
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,  // main sweep idle or delay not yet elapsed
    ST_ARMED = 2'd1,  // delay elapsed, waiting for a trigger
    ST_RUN   = 2'd2,  // delayed sweep gated on
    ST_SPENT = 2'd3   // delayed sweep done for this main sweep
  } dssState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic start;
    logic stop;
  } dssStrobe_t;

endpackage

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mainActive,
  input  logic       delayDone,
  input  logic       dlyTrig,
  input  logic       dlySweepEnd,
  input  logic       runMode,
  output dssStrobe_t strb,
  output dssState_t  state
);

  dssState_t stateNxt;

  always_comb begin
    stateNxt   = state;
    strb.start = 1'b0;
    strb.stop  = 1'b0;
    unique case (state)
      ST_WAIT: begin
        if (mainActive && delayDone) begin
          if (runMode) begin
            stateNxt   = ST_RUN;
            strb.start = 1'b1;
          end else begin
            stateNxt = ST_ARMED;
          end
        end
      end
      ST_ARMED: begin
        if (!mainActive) begin
          stateNxt = ST_WAIT;
        end else if (dlyTrig || runMode) begin
          stateNxt   = ST_RUN;
          strb.start = 1'b1;
        end
      end
      ST_RUN: begin
        if (!mainActive) begin
          stateNxt  = ST_WAIT;
          strb.stop = 1'b1;
        end else if (dlySweepEnd) begin
          stateNxt  = ST_SPENT;
          strb.stop = 1'b1;
        end
      end
      ST_SPENT: begin
        if (!mainActive) stateNxt = ST_WAIT;
      end
      default: stateNxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= stateNxt;
  end

endmodule

// File: rtl/dss_datapath.sv
module dss_datapath
  import dss_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] trigLevel,
  input  dssStrobe_t       strb,
  output logic             runMode,
  output logic             dlyGate,
  output logic             dispSel
);

  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  // The top end of the level range selects run-on-expiry mode.
  assign runMode = (trigLevel == LVL_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlyGate <= 1'b0;
      dispSel <= 1'b0;
    end else if (strb.stop) begin
      dlyGate <= 1'b0;
      dispSel <= 1'b0;
    end else if (strb.start) begin
      dlyGate <= 1'b1;
      dispSel <= 1'b1;
    end
  end

endmodule

// File: rtl/dly_sweep_start.sv
module dly_sweep_start
  import dss_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mainActive,
  input  logic             delayDone,
  input  logic             dlyTrig,
  input  logic [LVL_W-1:0] trigLevel,
  input  logic             dlySweepEnd,
  output logic             dlyGate,
  output logic             dispSel
);

  dssStrobe_t strb;
  dssState_t  state;
  logic       runMode;

  dss_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mainActive (mainActive),
    .delayDone  (delayDone),
    .dlyTrig    (dlyTrig),
    .dlySweepEnd(dlySweepEnd),
    .runMode    (runMode),
    .strb       (strb),
    .state      (state)
  );

  dss_datapath #(.LVL_W(LVL_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigLevel(trigLevel),
    .strb     (strb),
    .runMode  (runMode),
    .dlyGate  (dlyGate),
    .dispSel  (dispSel)
  );

endmodule

// File: rtl/dly_sweep_start_chk.sv
module dly_sweep_start_chk #(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mainActive,
  input logic             dlyTrig,
  input logic [LVL_W-1:0] trigLevel,
  input logic             dlySweepEnd,
  input logic             dlyGate,
  input logic             dispSel
);

  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  logic prevGate;
  logic startedThisMain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevGate        <= 1'b0;
      startedThisMain <= 1'b0;
    end else begin
      prevGate <= dlyGate;
      if (!mainActive)                startedThisMain <= 1'b0;
      else if (dlyGate && !prevGate)  startedThisMain <= 1'b1;
    end
  end

  assert_main_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mainActive |=> !dlyGate);

  assert_own_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dlyGate && dlySweepEnd) |=> !dlyGate);

  assert_only_in_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlyGate) |-> $past(mainActive));

  assert_once_per_main_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dlyGate && !prevGate) |-> !startedThisMain);

  assert_trig_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dlyGate) && $past(trigLevel != LVL_TOP)) |-> $past(dlyTrig));

  assert_disp_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dispSel == dlyGate);

endmodule

bind dly_sweep_start dly_sweep_start_chk #(.LVL_W(LVL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mainActive (mainActive),
  .dlyTrig    (dlyTrig),
  .trigLevel  (trigLevel),
  .dlySweepEnd(dlySweepEnd),
  .dlyGate    (dlyGate),
  .dispSel    (dispSel)
);

// File: tb/dly_sweep_start_tb.sv
module dly_sweep_start_tb_top;

  localparam int LVL_W = 4;
  localparam logic [LVL_W-1:0] TOP = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mainActive = 1'b0;
  logic delayDone = 1'b0;
  logic dlyTrig = 1'b0;
  logic [LVL_W-1:0] trigLevel = '0;
  logic dlySweepEnd = 1'b0;
  logic dlyGate;
  logic dispSel;

  always #4 clk = ~clk;  // 125 MHz

  dly_sweep_start #(.LVL_W(LVL_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mainActive (mainActive),
    .delayDone  (delayDone),
    .dlyTrig    (dlyTrig),
    .trigLevel  (trigLevel),
    .dlySweepEnd(dlySweepEnd),
    .dlyGate    (dlyGate),
    .dispSel    (dispSel)
  );

  typedef struct {
    logic  expGate;
    string req;
  } item_t;

  item_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // Driver: applies one cycle of inputs at the falling edge and queues the
  // output expected after the next rising edge.
  task automatic step(input logic rst, input logic main, input logic dd,
                      input logic trg, input logic [LVL_W-1:0] lvl,
                      input logic se, input logic exp, input string req);
    item_t it;
    @(negedge clk);
    rst_n       = rst;
    mainActive  = main;
    delayDone   = dd;
    dlyTrig     = trg;
    trigLevel   = lvl;
    dlySweepEnd = se;
    it.expGate  = exp;
    it.req      = req;
    expQ.push_back(it);
  endtask

  // Monitor: pops one expectation per rising edge, checks both outputs.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        nChecks++;
        if (dlyGate !== it.expGate) begin
          nFails++;
          $display("FAIL %s dlyGate actual=%b expected=%b", it.req, dlyGate, it.expGate);
        end
        nChecks++;
        if (dispSel !== it.expGate) begin
          nFails++;
          $display("FAIL %s/R10 dispSel actual=%b expected=%b", it.req, dispSel, it.expGate);
        end
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=%0d cycles expected<=5000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    // R1: reset
    step(0, 0, 0, 0, TOP, 0, 0, "R1");
    step(0, 1, 1, 0, TOP, 0, 0, "R1");
    step(1, 0, 0, 0, TOP, 0, 0, "R1");

    // Run-on-expiry mode
    step(1, 1, 0, 0, TOP, 0, 0, "R2");
    step(1, 1, 0, 1, TOP, 0, 0, "R5");   // trigger before expiry ignored
    step(1, 1, 1, 0, TOP, 0, 1, "R2");   // opens at once
    step(1, 1, 0, 0, TOP, 0, 1, "R2");
    step(1, 1, 0, 1, TOP, 0, 1, "R5");
    step(1, 1, 0, 0, TOP, 1, 0, "R7");   // own end
    step(1, 1, 1, 0, TOP, 0, 0, "R9");   // second expiry ignored
    step(1, 1, 0, 1, TOP, 0, 0, "R5");   // trigger after end ignored
    step(1, 0, 0, 0, TOP, 0, 0, "R9");

    // Triggered mode
    step(1, 1, 0, 0, 4'd7, 0, 0, "R4");
    step(1, 1, 0, 1, 4'd7, 0, 0, "R4");  // early trigger discarded
    step(1, 1, 0, 0, 4'd7, 0, 0, "R4");
    step(1, 1, 1, 1, 4'd7, 0, 0, "R3");  // coincident trigger rejected
    step(1, 1, 0, 0, 4'd7, 0, 0, "R3");
    step(1, 1, 0, 0, 4'd7, 0, 0, "R3");
    step(1, 1, 0, 1, 4'd7, 0, 1, "R3");  // first trigger after expiry
    step(1, 1, 0, 0, 4'd7, 0, 1, "R3");
    step(1, 1, 0, 1, 4'd7, 0, 1, "R3");
    step(1, 0, 0, 0, 4'd7, 0, 0, "R8");  // main ends first

    // Expiry outside a main sweep
    step(1, 0, 1, 0, TOP, 0, 0, "R6");
    step(1, 0, 0, 0, TOP, 0, 0, "R6");
    step(1, 1, 0, 0, TOP, 0, 0, "R6");   // no stale start
    step(1, 0, 1, 0, 4'd7, 0, 0, "R6");
    step(1, 1, 0, 1, 4'd7, 0, 0, "R6");  // not armed by out-of-sweep expiry
    step(1, 0, 0, 0, 4'd7, 0, 0, "R6");

    // New main sweep allows a new delayed sweep
    step(1, 1, 1, 0, TOP, 0, 1, "R9");
    step(1, 0, 0, 0, TOP, 0, 0, "R8");
    step(1, 1, 1, 0, TOP, 0, 1, "R9");
    step(1, 1, 0, 0, TOP, 1, 0, "R7");
    step(1, 0, 0, 0, TOP, 0, 0, "R9");

    // Level moved to the top end while armed
    step(1, 1, 1, 0, 4'd14, 0, 0, "R11"); // 14 is triggered mode
    step(1, 1, 0, 0, 4'd14, 0, 0, "R11");
    step(1, 1, 0, 0, TOP,   0, 1, "R11");
    step(1, 0, 0, 0, TOP,   0, 0, "R8");

    // Armed state cleared by main sweep end
    step(1, 1, 1, 0, 4'd3, 0, 0, "R8");
    step(1, 0, 0, 0, 4'd3, 0, 0, "R8");
    step(1, 1, 0, 1, 4'd3, 0, 0, "R8");
    step(1, 1, 0, 0, 4'd3, 0, 0, "R8");
    step(1, 0, 0, 0, 4'd3, 0, 0, "R8");

    @(posedge clk);
    #3;
    finishRun();
  end

endmodule